// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and calendar date in packed BCD byte registers. It advances them from a prescaled tick input that pulses 128 times per second. A free-running sub-second counter sits below the seconds field. Each time that counter wraps, the seconds field is bumped, and the increment ripples upward through minutes, hours, weekday, day of month, month and year. Month length and leap years are taken into account. A build option adds a BCD century byte that counts on from a year rollover.

Software uses a byte-wide register bus to stop the clock, hold the prescaler in reset, load any field and restart counting. A carry flag marks every seconds update. The intended read sequence is:

1. Clear the carry flag.
2. Read the date and time fields.
3. Read the flag again and retry if it has become set.

The flag can also raise an interrupt request when its enable bit is set.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, reading any field returns its reset value. Sub-second, seconds, minutes, hours, weekday and year read 00. Day and month read 01. The century reads 20. Both control registers read 00 and the interrupt request is low.
- R2: The field registers use these bus addresses: sub-second 0, seconds 1, minutes 2, hours 3, weekday 4, day 5, month 6, year 7, century 8, first control register 9, second control register 10. Every field is packed BCD with the tens digit in bits 7:4.
- R3: While counting, the sub-second counter at address 0 goes up by one on each tick. When it wraps from 127 to 0, the seconds field goes up by one. Bus writes to address 0 do not change the counter.
- R4: The second control register has three used bits: bit 0 starts counting, bit 3 enables the clock and bit 1 resets the prescaler. Counting happens only when bit 0 and bit 3 are both 1 and bit 1 is 0. While bit 1 is 1, the sub-second counter is held at 0. While counting is halted, ticks change nothing.
- R5: The time fields roll over in a cascade. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00 and advance both the weekday (which wraps from 6 to 0) and the day of month.
- R6: After the last day of the month, the day returns to 01. The last day is 31, 30 or 28, or 29 for February in a leap year. A year is a leap year when the BCD year byte is divisible by 4, and 00 counts as a leap year. Month goes from 12 to 01 and advances the year.
- R7: In four-digit year mode, a year rollover from 99 to 00 increments the century byte at address 8. The century itself wraps from 99 to 00.
- R8: Bit 7 of the first control register is the carry flag. It is set by every seconds update that comes from the sub-second wrap. Writing 0 to bit 7 clears it and writing 1 leaves it unchanged. If a clear write and a seconds update fall in the same cycle, the flag ends up set.
- R9: The interrupt request output is high exactly when the carry flag is set and bit 4 of the first control register (the carry interrupt enable) is 1.
- R10: A bus write to a field in the same cycle as that field's increment wins: the field takes the written value, and counting then continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled 128 Hz count enable, one cycle wide |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
Two pairs of events can land in one clock cycle, and each pair is forced on purpose.

The first pair is a software clear of the carry flag and the seconds update that sets it. The bench steps the sub-second counter to 127 with 127 ticks. It then applies the 128th tick in the same cycle as a write of 0 to the first control register. The carry flag must still read back as set, and the seconds field must have advanced.

The second pair is a bus write to the seconds field and that field's own increment. The bench drives the write together with the wrapping tick and expects the written value to win. After one more full second it expects the seconds to read the written value plus one.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef logic [7:0] bcd_t;

   // bus map of the block (index order of the time fields is behaviour)
   typedef enum logic [3:0] {
      RA_SUBSEC = 4'd0,
      RA_SEC    = 4'd1,
      RA_MIN    = 4'd2,
      RA_HOUR   = 4'd3,
      RA_WDAY   = 4'd4,
      RA_DAY    = 4'd5,
      RA_MON    = 4'd6,
      RA_YEAR   = 4'd7,
      RA_CENT   = 4'd8,
      RA_CTL_A  = 4'd9,
      RA_CTL_B  = 4'd10
   } reg_addr_e;

   localparam int NUM_FIELDS = 7;   // seconds .. year

   // index of each time field inside the field vector
   localparam int FI_SEC  = 0;
   localparam int FI_MIN  = 1;
   localparam int FI_HOUR = 2;
   localparam int FI_WDAY = 3;
   localparam int FI_DAY  = 4;
   localparam int FI_MON  = 5;
   localparam int FI_YEAR = 6;

   function automatic bcd_t bcd_step(input bcd_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by 4: (2*tens + units) mod 4 == 0
   function automatic logic bcd_leap(input bcd_t y);
      logic [4:0] s;
      s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
      return s[1:0] == 2'b00;
   endfunction

   function automatic bcd_t last_day(input bcd_t mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd_t field_floor(input int idx);
      return (idx == FI_DAY || idx == FI_MON) ? 8'h01 : 8'h00;
   endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (run && tick) cnt <= cnt + 1'b1;
   end

   assign wrap = run && tick && !clr && (cnt == TOP);

   // R4: without a running tick and without clear, the count holds
   assert_subsec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && tick) && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter bcd_t RESET_VAL = 8'h00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  bcd_t lo,
   input  bcd_t hi,
   input  logic wr,
   input  bcd_t wdata,
   output bcd_t value,
   output logic wrap
);
   always_ff @(posedge clk) begin
      if (!rst_n)   value <= RESET_VAL;
      else if (wr)  value <= wdata;
      else if (inc) value <= (value == hi) ? lo : bcd_step(value);
   end

   assign wrap = inc && (value == hi);

   // R2: a legal field stays legal BCD and within its ceiling after a step
   assert_field_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && value >= lo && value <= hi && value[3:0] <= 4'd9)
      |=> (value <= $past(hi)) && (value[3:0] <= 4'd9));

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_a,
   input  logic wr_b,
   input  logic wd_cf,
   input  logic wd_cie,
   input  logic wd_en,
   input  logic wd_prst,
   input  logic wd_start,
   input  logic sec_carry,
   output logic cf,
   output logic cie,
   output logic en,
   output logic prst,
   output logic start,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cf  <= 1'b0;
         cie <= 1'b0;
      end else begin
         if (sec_carry)          cf <= 1'b1;
         else if (wr_a && !wd_cf) cf <= 1'b0;
         if (wr_a) cie <= wd_cie;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         prst  <= 1'b0;
         start <= 1'b0;
      end else if (wr_b) begin
         en    <= wd_en;
         prst  <= wd_prst;
         start <= wd_start;
      end
   end

   assign irq = cf && cie;

   // R8: a seconds update always leaves the flag set
   assert_carry_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_carry |=> cf);

   // R8: only a zero written to the flag bit removes it
   assert_carry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cf && !(wr_a && !wd_cf)) |=> cf);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import rtc_cal_pkg::*;
#(
   parameter int   SUBSEC_W        = 7,
   parameter int   ADDR_W          = 4,
   parameter bit   FOUR_DIGIT_YEAR = 1'b1,
   parameter bcd_t CENTURY_RESET   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              carry_irq
);
   localparam int PAD_W = 8 - SUBSEC_W;

   // elaboration-time parameter checks
   generate
      if (SUBSEC_W < 2 || SUBSEC_W > 8) begin : g_bad_subsec
         initial $error("SUBSEC_W must lie in 2..8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         initial $error("ADDR_W must be at least 4");
      end
   endgenerate

   // control
   logic cf, cie, en, prst, start, run;
   logic wr_a, wr_b;

   assign wr_a = bus_wr && (bus_addr == ADDR_W'(RA_CTL_A));
   assign wr_b = bus_wr && (bus_addr == ADDR_W'(RA_CTL_B));

   // sub-second
   logic [SUBSEC_W-1:0] sub_cnt;
   logic                sub_wrap;

   assign run = start && en && !prst;

   rtc_subsec #(.W(SUBSEC_W)) u_subsec (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .clr  (prst),
      .tick (tick),
      .cnt  (sub_cnt),
      .wrap (sub_wrap)
   );

   rtc_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_a     (wr_a),
      .wr_b     (wr_b),
      .wd_cf    (bus_wdata[7]),
      .wd_cie   (bus_wdata[4]),
      .wd_en    (bus_wdata[3]),
      .wd_prst  (bus_wdata[1]),
      .wd_start (bus_wdata[0]),
      .sec_carry(sub_wrap),
      .cf       (cf),
      .cie      (cie),
      .en       (en),
      .prst     (prst),
      .start    (start),
      .irq      (carry_irq)
   );

   // time and date fields
   logic [NUM_FIELDS-1:0][7:0] f_val, f_lo, f_hi;
   logic [NUM_FIELDS-1:0]      f_inc, f_wrap, f_wr;

   always_comb begin
      f_lo = '0;
      f_hi = '0;
      f_lo[FI_SEC]  = 8'h00;  f_hi[FI_SEC]  = 8'h59;
      f_lo[FI_MIN]  = 8'h00;  f_hi[FI_MIN]  = 8'h59;
      f_lo[FI_HOUR] = 8'h00;  f_hi[FI_HOUR] = 8'h23;
      f_lo[FI_WDAY] = 8'h00;  f_hi[FI_WDAY] = 8'h06;
      f_lo[FI_DAY]  = 8'h01;
      f_hi[FI_DAY]  = last_day(f_val[FI_MON], bcd_leap(f_val[FI_YEAR]));
      f_lo[FI_MON]  = 8'h01;  f_hi[FI_MON]  = 8'h12;
      f_lo[FI_YEAR] = 8'h00;  f_hi[FI_YEAR] = 8'h99;
   end

   // carry cascade: hour wrap feeds weekday and day side by side
   always_comb begin
      f_inc[FI_SEC]  = sub_wrap;
      f_inc[FI_MIN]  = f_wrap[FI_SEC];
      f_inc[FI_HOUR] = f_wrap[FI_MIN];
      f_inc[FI_WDAY] = f_wrap[FI_HOUR];
      f_inc[FI_DAY]  = f_wrap[FI_HOUR];
      f_inc[FI_MON]  = f_wrap[FI_DAY];
      f_inc[FI_YEAR] = f_wrap[FI_MON];
   end

   generate
      for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
         assign f_wr[k] = bus_wr && (bus_addr == ADDR_W'(k + 1));
         rtc_bcd_field #(.RESET_VAL(field_floor(k))) u_field (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (f_inc[k]),
            .lo   (f_lo[k]),
            .hi   (f_hi[k]),
            .wr   (f_wr[k]),
            .wdata(bus_wdata),
            .value(f_val[k]),
            .wrap (f_wrap[k])
         );
      end
   endgenerate

   // optional century byte
   bcd_t cent_val;

   generate
      if (FOUR_DIGIT_YEAR) begin : g_century
         logic cent_wr;
         logic cent_wrap;
         assign cent_wr = bus_wr && (bus_addr == ADDR_W'(RA_CENT));
         rtc_bcd_field #(.RESET_VAL(CENTURY_RESET)) u_cent (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (f_wrap[FI_YEAR]),
            .lo   (8'h00),
            .hi   (8'h99),
            .wr   (cent_wr),
            .wdata(bus_wdata),
            .value(cent_val),
            .wrap (cent_wrap)
         );
      end else begin : g_two_digit
         assign cent_val = 8'h00;
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         ADDR_W'(RA_SUBSEC): bus_rdata = {{PAD_W{1'b0}}, sub_cnt};
         ADDR_W'(RA_SEC):    bus_rdata = f_val[FI_SEC];
         ADDR_W'(RA_MIN):    bus_rdata = f_val[FI_MIN];
         ADDR_W'(RA_HOUR):   bus_rdata = f_val[FI_HOUR];
         ADDR_W'(RA_WDAY):   bus_rdata = f_val[FI_WDAY];
         ADDR_W'(RA_DAY):    bus_rdata = f_val[FI_DAY];
         ADDR_W'(RA_MON):    bus_rdata = f_val[FI_MON];
         ADDR_W'(RA_YEAR):   bus_rdata = f_val[FI_YEAR];
         ADDR_W'(RA_CENT):   bus_rdata = cent_val;
         ADDR_W'(RA_CTL_A):  bus_rdata = {cf, 2'b00, cie, 4'b0000};
         ADDR_W'(RA_CTL_B):  bus_rdata = {4'b0000, en, 1'b0, prst, start};
         default:            bus_rdata = 8'h00;
      endcase
   end

   // R3: a sub-second wrap moves the seconds unless software writes them
   assert_sec_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_wrap && !f_wr[FI_SEC]) |=> (f_val[FI_SEC] != $past(f_val[FI_SEC])));

   // R9: the request only rises after a seconds update or an enable write
   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carry_irq) |-> ($past(sub_wrap) || $past(wr_a && bus_wdata[4])));

   // R10: a field write always lands, whatever the cascade does
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      f_wr[FI_SEC] |=> (f_val[FI_SEC] == $past(bus_wdata)));

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       carry_irq;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   bcd_calendar_clock dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .carry_irq(carry_irq)
   );

   // start fields s,m,h,w,d,mo,y,c then expected fields in the same order
   localparam logic [127:0] VEC [15] = '{
      {64'h00_00_00_00_01_01_24_20, 64'h01_00_00_00_01_01_24_20},
      {64'h59_34_12_03_10_05_24_20, 64'h00_35_12_03_10_05_24_20},
      {64'h59_59_23_06_15_03_24_20, 64'h00_00_00_00_16_03_24_20},
      {64'h59_59_23_02_31_01_25_20, 64'h00_00_00_03_01_02_25_20},
      {64'h59_59_23_01_28_02_23_20, 64'h00_00_00_02_01_03_23_20},
      {64'h59_59_23_01_28_02_24_20, 64'h00_00_00_02_29_02_24_20},
      {64'h59_59_23_04_29_02_24_20, 64'h00_00_00_05_01_03_24_20},
      {64'h59_59_23_05_30_04_26_20, 64'h00_00_00_06_01_05_26_20},
      {64'h59_59_23_06_31_12_99_20, 64'h00_00_00_00_01_01_00_21},
      {64'h59_59_23_00_28_02_00_21, 64'h00_00_00_01_29_02_00_21},
      {64'h59_59_23_03_30_11_30_20, 64'h00_00_00_04_01_12_30_20},
      {64'h59_59_23_06_31_12_99_99, 64'h00_00_00_00_01_01_00_00},
      {64'h59_59_23_03_30_06_18_20, 64'h00_00_00_04_01_07_18_20},
      {64'h59_59_23_03_28_02_96_20, 64'h00_00_00_04_29_02_96_20},
      {64'h59_59_23_03_28_02_98_20, 64'h00_00_00_04_01_03_98_20}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   // the tick that wraps the sub-second counter, together with a bus write
   task automatic tick_with_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      tick = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      tick = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] rst_exp [11];
      rst_exp = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01,
                  8'h00, 8'h20, 8'h00, 8'h00};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values at every address
      for (int a = 0; a < 11; a++) begin
         rd(4'(a), v);
         chk("R1 reset value", v, rst_exp[a]);
      end
      chk("R1 irq low", {7'd0, carry_irq}, 8'h00);

      // vector table: one second elapses from each start state (R5 R6 R7)
      for (int i = 0; i < 15; i++) begin
         wr(4'd10, 8'h0A);
         for (int f = 0; f < 8; f++) wr(4'(f + 1), VEC[i][127 - 8*f -: 8]);
         wr(4'd10, 8'h09);
         ticks(128);
         wr(4'd10, 8'h08);
         for (int f = 0; f < 8; f++) begin
            rd(4'(f + 1), v);
            chk($sformatf("R5 R6 R7 vector %0d field %0d", i, f), v, VEC[i][63 - 8*f -: 8]);
         end
      end

      // R4: halted combinations ignore ticks
      wr(4'd10, 8'h0A);
      wr(4'd10, 8'h00);
      ticks(5);
      rd(4'd0, v); chk("R4 halted all off", v, 8'h00);
      wr(4'd10, 8'h08);
      ticks(5);
      rd(4'd0, v); chk("R4 enable without start", v, 8'h00);
      wr(4'd10, 8'h01);
      ticks(5);
      rd(4'd0, v); chk("R4 start without enable", v, 8'h00);

      // R3: counting and ignored write
      wr(4'd10, 8'h09);
      ticks(5);
      rd(4'd0, v); chk("R3 sub-second count", v, 8'h05);
      wr(4'd0, 8'h55);
      rd(4'd0, v); chk("R3 write ignored", v, 8'h05);

      // R4: prescaler reset clears and holds
      wr(4'd10, 8'h0B);
      rd(4'd0, v); chk("R4 prescaler clear", v, 8'h00);
      ticks(4);
      rd(4'd0, v); chk("R4 prescaler hold", v, 8'h00);
      rd(4'd10, v); chk("R4 control readback", v, 8'h0B);

      // R8: flag clear collides with the seconds update
      wr(4'd9, 8'h00);
      wr(4'd1, 8'h05);
      wr(4'd10, 8'h09);
      ticks(127);
      rd(4'd9, v); chk("R8 no flag before wrap", v, 8'h00);
      tick_with_write(4'd9, 8'h00);
      rd(4'd9, v); chk("R8 set wins over clear", v, 8'h80);
      rd(4'd1, v); chk("R3 seconds advanced", v, 8'h06);
      wr(4'd9, 8'h90);
      rd(4'd9, v); chk("R8 writing one keeps flag", v, 8'h90);
      chk("R9 irq with enable", {7'd0, carry_irq}, 8'h01);
      wr(4'd9, 8'h80);
      chk("R9 irq masked", {7'd0, carry_irq}, 8'h00);
      wr(4'd9, 8'h10);
      rd(4'd9, v); chk("R8 writing zero clears", v, 8'h10);
      chk("R9 irq without flag", {7'd0, carry_irq}, 8'h00);

      // R10: seconds write collides with the seconds increment
      wr(4'd10, 8'h0A);
      wr(4'd9, 8'h00);
      wr(4'd1, 8'h10);
      wr(4'd2, 8'h07);
      wr(4'd10, 8'h09);
      ticks(127);
      tick_with_write(4'd1, 8'h30);
      rd(4'd1, v); chk("R10 write wins", v, 8'h30);
      rd(4'd0, v); chk("R10 sub-second wrapped", v, 8'h00);
      ticks(128);
      rd(4'd1, v); chk("R10 resumes from written", v, 8'h31);
      rd(4'd2, v); chk("R10 minutes untouched", v, 8'h07);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule